// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Manager

This block keeps the transmit and receive buffer descriptors of an Ethernet MAC in a small internal memory. A host reaches that memory, together with a handful of control registers, over a simple 32-bit register bus with combinational read data. One descriptor table is shared by both directions. A programmable count splits it: the first entries form the transmit ring and the remaining entries form the receive ring.

Two walkers step through their rings independently. The transmit walker finds a descriptor that software has marked ready and raises a request towards a frame engine. On the engine's done pulse it writes the completion status back into the descriptor and hands ownership back to software. The receive walker presents the current empty buffer. When a frame arrives it stores the length and status and releases the descriptor; if no empty descriptor is waiting, the frame is dropped and a busy event is flagged. Completion events feed an interrupt source register with write-one-to-clear bits and a mask that gates a single interrupt line.

Top module: `bd_ring_mgr`

## Requirements
- R1: After reset the mode register (byte 0x00) reads 0, the source register (0x04) reads 0, the mask register (0x08) reads 0, the descriptor-count register (0x20) reads 64, `irq` is low and `tx_req` is low.
- R2: A write to the count register stores the written value, except that any value above 128 is stored as 128.
- R3: Descriptor i occupies byte offsets 0x400+8*i (control/status word) and 0x404+8*i (buffer address word), and both words read back what the host last wrote.
- R4: While transmit is enabled (mode bit 1), a descriptor at the transmit pointer with bit 15 (ready) set causes `tx_req` to rise one cycle later and stay high until `tx_done`. During that time `tx_len` shows bits 31:16, `tx_pad` bit 12, `tx_crc` bit 11 and `tx_addr` the address word.
- R5: At `tx_done` the descriptor word becomes: bits 31:16 and 14:9 unchanged, bit 15 cleared, bits 8:0 replaced by `tx_stat`.
- R6: With receive enabled (mode bit 0) and the current receive descriptor having bit 15 (empty) set, an `rx_arrive` pulse writes `rx_len` into bits 31:16 and `rx_stat` into bits 8:0, clears bit 15 and keeps bits 14:9. `rx_buf_addr` shows the current descriptor's address word, and `rx_buf_ok` is high while receive is enabled and that descriptor is empty.
- R7: An `rx_arrive` while receive is enabled and the current descriptor has bit 15 clear sets source bit 4 (busy). It leaves the descriptor and the receive pointer unchanged.
- R8: After a completed descriptor with bit 13 (wrap) set, the pointer returns to the first entry of its own ring: index 0 for transmit, index N (the count register) for receive. Otherwise it moves to the next index.
- R9: A completion sets a source bit only if the descriptor's bit 14 is set. Transmit sets bit 0 if none of status bits 0, 2, 3 or 8 is set, and bit 1 otherwise. Receive sets bit 2 if none of status bits 0, 1, 2, 3, 5 or 6 is set, and bit 3 otherwise; it also sets bit 6 when status bit 8 (control frame) is set.
- R10: Writing ones to the source register clears those bits. `irq` is high exactly when a set source bit has its mask bit set.
- R11: With an enable bit clear, that direction makes no requests, ignores `rx_arrive` (no descriptor or source change), and holds its pointer at its ring start, so re-enabling begins at index 0 (transmit) or index N (receive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hb_wr | input | 1 | Host write strobe |
| hb_addr | input | 11 | Host byte address |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Host read data for hb_addr (combinational) |
| tx_req | output | 1 | Transmit descriptor handed to the engine |
| tx_len | output | 16 | Frame length of the requested descriptor |
| tx_addr | output | 32 | Buffer address of the requested descriptor |
| tx_pad | output | 1 | Padding enable of the requested descriptor |
| tx_crc | output | 1 | CRC enable of the requested descriptor |
| tx_done | input | 1 | Engine finished the requested frame |
| tx_stat | input | 9 | Transmit completion status |
| rx_arrive | input | 1 | A received frame is complete |
| rx_len | input | 16 | Received length including CRC bytes |
| rx_stat | input | 9 | Receive completion status |
| rx_buf_addr | output | 32 | Buffer address of the current receive descriptor |
| rx_buf_ok | output | 1 | Current receive descriptor is empty and receive is enabled |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume that the host never rewrites a descriptor whose ownership bit is set, never changes the count register while receive is enabled, and that `tx_done` arrives only while `tx_req` is high. The directed bench keeps to these rules: it sets up descriptors and the count before it sets an enable bit, it rewrites a descriptor only after the block has handed it back, and it pulses `tx_done` only after it has seen `tx_req`. Under these rules the ownership, pointer-step and wrap properties follow the descriptors exactly as software laid them out.

// File: rtl/bdr_pkg.sv
`timescale 1ns/1ps
package bdr_pkg;
  // descriptor control/status word bit positions
  localparam int BD_OWN  = 15;
  localparam int BD_IRQ  = 14;
  localparam int BD_WRAP = 13;
  localparam int BD_PAD  = 12;
  localparam int BD_CRC  = 11;
  localparam int ST_W    = 9;
  // interrupt source bit positions
  localparam int SRC_W   = 7;
  localparam int S_TXF   = 0;
  localparam int S_TXE   = 1;
  localparam int S_RXF   = 2;
  localparam int S_RXE   = 3;
  localparam int S_BUSY  = 4;
  localparam int S_RXC   = 6;
  // register byte offsets
  localparam logic [7:0] OFS_MODE  = 8'h00;
  localparam logic [7:0] OFS_SRC   = 8'h04;
  localparam logic [7:0] OFS_MASK  = 8'h08;
  localparam logic [7:0] OFS_COUNT = 8'h20;

  typedef struct packed {
    logic fire;
    logic irq;
    logic err;
    logic ctl;
  } bd_evt_t;

  function automatic logic [31:0] tx_close(input logic [31:0] w, input logic [ST_W-1:0] st);
    return {w[31:16], 1'b0, w[14:ST_W], st};
  endfunction

  function automatic logic [31:0] rx_close(input logic [31:0] w, input logic [15:0] len,
                                           input logic [ST_W-1:0] st);
    return {len, 1'b0, w[14:ST_W], st};
  endfunction

  function automatic logic tx_failed(input logic [ST_W-1:0] st);
    return st[0] | st[2] | st[3] | st[8];
  endfunction

  function automatic logic rx_failed(input logic [ST_W-1:0] st);
    return st[0] | st[1] | st[2] | st[3] | st[5] | st[6];
  endfunction

  function automatic logic [SRC_W-1:0] src_set(input bd_evt_t t, input bd_evt_t r, input logic busy);
    logic [SRC_W-1:0] s;
    s         = '0;
    s[S_TXF]  = t.fire & t.irq & ~t.err;
    s[S_TXE]  = t.fire & t.irq & t.err;
    s[S_RXF]  = r.fire & r.irq & ~r.err;
    s[S_RXE]  = r.fire & r.irq & r.err;
    s[S_RXC]  = r.fire & r.irq & r.ctl;
    s[S_BUSY] = busy;
    return s;
  endfunction
endpackage

// File: rtl/bdr_regs.sv
`timescale 1ns/1ps
module bdr_regs
  import bdr_pkg::*;
#(
  parameter int MAX_BD    = 128,
  parameter int CNT_W     = 8,
  parameter int RST_COUNT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       ofs,
  input  logic [31:0]      wdata,
  input  bd_evt_t          tx_evt,
  input  bd_evt_t          rx_evt,
  input  logic             rx_busy,
  output logic [31:0]      rd_data,
  output logic             tx_en,
  output logic             rx_en,
  output logic [CNT_W-1:0] tx_count,
  output logic [SRC_W-1:0] src_q,
  output logic [SRC_W-1:0] mask_q,
  output logic             irq
);
  function automatic logic [CNT_W-1:0] clamp_count(input logic [31:0] v);
    if (v > 32'(MAX_BD)) return CNT_W'(MAX_BD);
    return v[CNT_W-1:0];
  endfunction

  logic [SRC_W-1:0] clr;
  assign clr = (wr_en && ofs == OFS_SRC) ? wdata[SRC_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en    <= 1'b0;
      rx_en    <= 1'b0;
      tx_count <= CNT_W'(RST_COUNT);
      src_q    <= '0;
      mask_q   <= '0;
    end else begin
      if (wr_en && ofs == OFS_MODE) begin
        rx_en <= wdata[0];
        tx_en <= wdata[1];
      end
      if (wr_en && ofs == OFS_MASK)  mask_q   <= wdata[SRC_W-1:0];
      if (wr_en && ofs == OFS_COUNT) tx_count <= clamp_count(wdata);
      // new events win over a clear in the same cycle
      src_q <= (src_q & ~clr) | src_set(tx_evt, rx_evt, rx_busy);
    end
  end

  assign irq = |(src_q & mask_q);

  always_comb begin
    case (ofs)
      OFS_MODE:  rd_data = {30'b0, tx_en, rx_en};
      OFS_SRC:   rd_data = 32'(src_q);
      OFS_MASK:  rd_data = 32'(mask_q);
      OFS_COUNT: rd_data = 32'(tx_count);
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/bdr_desc_mem.sv
`timescale 1ns/1ps
module bdr_desc_mem #(
  parameter int DEPTH = 128,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_we,
  input  logic             h_sel_addr,
  input  logic [IDX_W-1:0] h_idx,
  input  logic [31:0]      h_wdata,
  output logic [31:0]      h_stat,
  output logic [31:0]      h_addr,
  input  logic [IDX_W-1:0] t_idx,
  input  logic             t_we,
  input  logic [31:0]      t_word,
  output logic [31:0]      t_stat,
  output logic [31:0]      t_addr,
  input  logic [IDX_W-1:0] r_idx,
  input  logic             r_we,
  input  logic [31:0]      r_word,
  output logic [31:0]      r_stat,
  output logic [31:0]      r_addr
);
  logic [31:0] stat_q [DEPTH];
  logic [31:0] addr_q [DEPTH];

  // control/status words: host writes first, walker write-back takes precedence
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stat_q[i] <= '0;
    end else begin
      if (h_we && !h_sel_addr) stat_q[h_idx] <= h_wdata;
      if (t_we) stat_q[t_idx] <= t_word;
      if (r_we) stat_q[r_idx] <= r_word;
    end
  end

  always_ff @(posedge clk) begin
    if (h_we && h_sel_addr) addr_q[h_idx] <= h_wdata;
  end

  assign h_stat = stat_q[h_idx];
  assign h_addr = addr_q[h_idx];
  assign t_stat = stat_q[t_idx];
  assign t_addr = addr_q[t_idx];
  assign r_stat = stat_q[r_idx];
  assign r_addr = addr_q[r_idx];
endmodule

// File: rtl/bdr_tx_walk.sv
`timescale 1ns/1ps
module bdr_tx_walk
  import bdr_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [31:0]      cur_word,
  input  logic             done,
  input  logic [ST_W-1:0]  st,
  output logic [IDX_W-1:0] ptr,
  output logic             req,
  output logic             wb_en,
  output logic [31:0]      wb_word,
  output bd_evt_t          evt
);
  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p, input logic wrap);
    return wrap ? '0 : p + 1'b1;
  endfunction

  logic busy_q;
  logic start, fire;

  assign start = en & ~busy_q & cur_word[BD_OWN];
  assign fire  = en & busy_q & done;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      busy_q <= 1'b0;
      ptr    <= '0;
    end else if (fire) begin
      busy_q <= 1'b0;
      ptr    <= step(ptr, cur_word[BD_WRAP]);
    end else if (start) begin
      busy_q <= 1'b1;
    end
  end

  assign req     = busy_q & en;
  assign wb_en   = fire;
  assign wb_word = tx_close(cur_word, st);
  assign evt     = '{fire: fire, irq: cur_word[BD_IRQ], err: tx_failed(st), ctl: 1'b0};
endmodule

// File: rtl/bdr_rx_walk.sv
`timescale 1ns/1ps
module bdr_rx_walk
  import bdr_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [31:0]      cur_word,
  input  logic             arrive,
  input  logic [15:0]      len,
  input  logic [ST_W-1:0]  st,
  output logic [IDX_W-1:0] ptr,
  output logic             wb_en,
  output logic [31:0]      wb_word,
  output bd_evt_t          evt,
  output logic             busy_evt,
  output logic             buf_ok
);
  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p,
                                            input logic [IDX_W-1:0] first, input logic wrap);
    return wrap ? first : p + 1'b1;
  endfunction

  logic take;
  assign buf_ok   = en & cur_word[BD_OWN];
  assign take     = buf_ok & arrive;
  assign busy_evt = en & arrive & ~cur_word[BD_OWN];

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (!en)    ptr <= start_idx;
    else if (take)   ptr <= step(ptr, start_idx, cur_word[BD_WRAP]);
  end

  assign wb_en   = take;
  assign wb_word = rx_close(cur_word, len, st);
  assign evt     = '{fire: take, irq: cur_word[BD_IRQ], err: rx_failed(st), ctl: st[8]};
endmodule

// File: rtl/bd_ring_mgr.sv
`timescale 1ns/1ps
module bd_ring_mgr
  import bdr_pkg::*;
#(
  parameter int MAX_BD    = 128,
  parameter int ADDR_W    = 11,
  parameter int BD_BASE   = 'h400,
  parameter int RST_COUNT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_wr,
  input  logic [ADDR_W-1:0] hb_addr,
  input  logic [31:0]       hb_wdata,
  output logic [31:0]       hb_rdata,
  output logic              tx_req,
  output logic [15:0]       tx_len,
  output logic [31:0]       tx_addr,
  output logic              tx_pad,
  output logic              tx_crc,
  input  logic              tx_done,
  input  logic [8:0]        tx_stat,
  input  logic              rx_arrive,
  input  logic [15:0]       rx_len,
  input  logic [8:0]        rx_stat,
  output logic [31:0]       rx_buf_addr,
  output logic              rx_buf_ok,
  output logic              irq
);
  localparam int IDX_W = $clog2(MAX_BD);
  localparam int CNT_W = $clog2(MAX_BD + 1);
  localparam int BD_SPAN = MAX_BD * 8;

  // host decode
  logic [ADDR_W-1:0] desc_off;
  logic desc_hit, reg_hit;
  assign desc_off = hb_addr - ADDR_W'(BD_BASE);
  assign desc_hit = (hb_addr >= ADDR_W'(BD_BASE)) && (32'(desc_off) < 32'(BD_SPAN));
  assign reg_hit  = (32'(hb_addr) < 32'h100);

  logic [IDX_W-1:0] h_idx;
  assign h_idx = desc_off[IDX_W+2:3];

  // internal events, named for the checker
  logic [IDX_W-1:0] tx_ptr, rx_ptr, rx_start;
  logic [31:0]      tx_word, rx_word, h_stat, h_addrw, reg_rd;
  logic             tx_fire, rx_fire, rx_busy, tx_en, rx_en;
  logic [31:0]      tx_wb_word, rx_wb_word;
  logic [CNT_W-1:0] tx_count;
  logic [SRC_W-1:0] src_q, mask_q;
  bd_evt_t          tx_evt, rx_evt;

  assign rx_start = IDX_W'(tx_count);
  assign tx_fire  = tx_evt.fire;
  assign rx_fire  = rx_evt.fire;

  bdr_regs #(.MAX_BD(MAX_BD), .CNT_W(CNT_W), .RST_COUNT(RST_COUNT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(hb_wr & reg_hit), .ofs(hb_addr[7:0]), .wdata(hb_wdata),
    .tx_evt(tx_evt), .rx_evt(rx_evt), .rx_busy(rx_busy), .rd_data(reg_rd),
    .tx_en(tx_en), .rx_en(rx_en), .tx_count(tx_count), .src_q(src_q), .mask_q(mask_q), .irq(irq)
  );

  logic [31:0] tx_addrw, rx_addrw;

  bdr_desc_mem #(.DEPTH(MAX_BD), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .h_we(hb_wr & desc_hit), .h_sel_addr(desc_off[2]), .h_idx(h_idx), .h_wdata(hb_wdata),
    .h_stat(h_stat), .h_addr(h_addrw),
    .t_idx(tx_ptr), .t_we(tx_fire), .t_word(tx_wb_word), .t_stat(tx_word), .t_addr(tx_addrw),
    .r_idx(rx_ptr), .r_we(rx_fire), .r_word(rx_wb_word), .r_stat(rx_word), .r_addr(rx_addrw)
  );

  logic tx_wb_en, rx_wb_en;

  bdr_tx_walk #(.IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .cur_word(tx_word), .done(tx_done), .st(tx_stat),
    .ptr(tx_ptr), .req(tx_req), .wb_en(tx_wb_en), .wb_word(tx_wb_word), .evt(tx_evt)
  );

  bdr_rx_walk #(.IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .start_idx(rx_start), .cur_word(rx_word),
    .arrive(rx_arrive), .len(rx_len), .st(rx_stat), .ptr(rx_ptr), .wb_en(rx_wb_en),
    .wb_word(rx_wb_word), .evt(rx_evt), .busy_evt(rx_busy), .buf_ok(rx_buf_ok)
  );

  assign tx_len      = tx_word[31:16];
  assign tx_pad      = tx_word[BD_PAD];
  assign tx_crc      = tx_word[BD_CRC];
  assign tx_addr     = tx_addrw;
  assign rx_buf_addr = rx_addrw;

  always_comb begin
    if (desc_hit)     hb_rdata = desc_off[2] ? h_addrw : h_stat;
    else if (reg_hit) hb_rdata = reg_rd;
    else              hb_rdata = '0;
  end

  // write-back strobes are the event fire bits; kept as named wires
  logic unused_ok;
  assign unused_ok = &{1'b0, tx_wb_en, rx_wb_en, desc_off[1:0]};
endmodule

// File: rtl/bdr_checker.sv
`timescale 1ns/1ps
module bdr_checker #(
  parameter int IDX_W  = 7,
  parameter int CNT_W  = 8,
  parameter int MAX_BD = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             rx_en,
  input logic             tx_req,
  input logic             tx_done,
  input logic [IDX_W-1:0] tx_ptr,
  input logic [31:0]      tx_word,
  input logic             tx_fire,
  input logic             rx_arrive,
  input logic             rx_fire,
  input logic             rx_busy,
  input logic [IDX_W-1:0] rx_ptr,
  input logic [IDX_W-1:0] rx_start,
  input logic [31:0]      rx_word,
  input logic [6:0]       src_q,
  input logic [6:0]       mask_q,
  input logic             irq,
  input logic [CNT_W-1:0] tx_count
);
  p_count_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tx_count) <= 32'(MAX_BD));

  p_req_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> tx_word[15]);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_done) |=> (tx_req || !tx_en));

  p_tx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && !tx_word[13]) |=> (tx_ptr == IDX_W'($past(tx_ptr) + 1'b1) || !tx_en));

  p_tx_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && tx_word[13]) |=> (tx_ptr == '0));

  p_rx_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && rx_word[13]) |=> (rx_ptr == rx_start));

  p_busy_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |=> ($stable(rx_ptr) && src_q[4]));

  p_tx_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && tx_word[14]) |=> (src_q[0] || src_q[1]));

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  p_rx_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && rx_arrive) |-> (!rx_fire && !rx_busy));

  p_tx_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_req);
endmodule

bind bd_ring_mgr bdr_checker #(.IDX_W(IDX_W), .CNT_W(CNT_W), .MAX_BD(MAX_BD)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .tx_req(tx_req), .tx_done(tx_done),
  .tx_ptr(tx_ptr), .tx_word(tx_word), .tx_fire(tx_fire), .rx_arrive(rx_arrive),
  .rx_fire(rx_fire), .rx_busy(rx_busy), .rx_ptr(rx_ptr), .rx_start(rx_start), .rx_word(rx_word),
  .src_q(src_q), .mask_q(mask_q), .irq(irq), .tx_count(tx_count)
);

// File: tb/sim_bd_ring_mgr.sv
`timescale 1ns/1ps
module sim_bd_ring_mgr;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        hb_wr = 1'b0;
  logic [10:0] hb_addr = '0;
  logic [31:0] hb_wdata = '0, hb_rdata;
  logic        tx_req, tx_pad, tx_crc, tx_done = 1'b0;
  logic [15:0] tx_len;
  logic [31:0] tx_addr, rx_buf_addr;
  logic [8:0]  tx_stat = '0, rx_stat = '0;
  logic        rx_arrive = 1'b0, rx_buf_ok, irq;
  logic [15:0] rx_len = '0;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  bd_ring_mgr u0 (
    .clk(clk), .rst_n(rst_n), .hb_wr(hb_wr), .hb_addr(hb_addr), .hb_wdata(hb_wdata),
    .hb_rdata(hb_rdata), .tx_req(tx_req), .tx_len(tx_len), .tx_addr(tx_addr), .tx_pad(tx_pad),
    .tx_crc(tx_crc), .tx_done(tx_done), .tx_stat(tx_stat), .rx_arrive(rx_arrive),
    .rx_len(rx_len), .rx_stat(rx_stat), .rx_buf_addr(rx_buf_addr), .rx_buf_ok(rx_buf_ok),
    .irq(irq)
  );

  localparam logic [10:0] A_MODE = 11'h000, A_SRC = 11'h004, A_MASK = 11'h008, A_CNT = 11'h020;

  function automatic logic [10:0] bd_at(input int i, input int word);
    return 11'(32'h400 + i * 8 + word * 4);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    hb_wr = 1'b1; hb_addr = a; hb_wdata = d;
    @(negedge clk);
    hb_wr = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] d);
    hb_addr = a;
    #1;
    d = hb_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_req(input string tag);
    int k;
    k = 0;
    while (!tx_req && k < 40) begin @(negedge clk); k++; end
    check(tag, 32'(tx_req), 32'd1);
  endtask

  task automatic finish_tx(input logic [8:0] st);
    tx_stat = st; tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic frame_in(input logic [15:0] len, input logic [8:0] st);
    @(negedge clk);
    rx_len = len; rx_stat = st; rx_arrive = 1'b1;
    @(negedge clk);
    rx_arrive = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_MODE, v);  check("R1 mode", v, 32'h0);
    rd(A_SRC, v);   check("R1 source", v, 32'h0);
    rd(A_MASK, v);  check("R1 mask", v, 32'h0);
    rd(A_CNT, v);   check("R1 count", v, 32'd64);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 tx_req", 32'(tx_req), 32'h0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(A_CNT, 32'd200);  rd(A_CNT, v); check("R2 clamp 200", v, 32'd128);
    wr(A_CNT, 32'd129);  rd(A_CNT, v); check("R2 clamp 129", v, 32'd128);
    wr(A_CNT, 32'd4);    rd(A_CNT, v); check("R2 count 4", v, 32'd4);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(bd_at(3, 0), 32'h1234_5678);
    wr(bd_at(3, 1), 32'hCAFE_0000);
    rd(11'h418, v); check("R3 stat word 3", v, 32'h1234_5678);
    rd(11'h41C, v); check("R3 addr word 3", v, 32'hCAFE_0000);
    rd(11'h410, v); check("R3 neighbour untouched", v, 32'h0);
    wr(bd_at(3, 0), 32'h0);
  endtask

  task automatic t_tx;
    logic [31:0] v;
    wr(bd_at(0, 0), 32'h003C_D800); wr(bd_at(0, 1), 32'h0000_1000);
    wr(bd_at(1, 0), 32'h0064_E800); wr(bd_at(1, 1), 32'h0000_2000);
    wr(bd_at(2, 0), 32'h0010_8000); wr(bd_at(2, 1), 32'h0000_2200);
    wr(A_MODE, 32'h2);
    wait_req("R4 request desc0");
    check("R4 tx_addr", tx_addr, 32'h0000_1000);
    check("R4 tx_len", 32'(tx_len), 32'd60);
    check("R4 tx_pad", 32'(tx_pad), 32'd1);
    check("R4 tx_crc", 32'(tx_crc), 32'd1);
    finish_tx(9'h052);
    rd(bd_at(0, 0), v); check("R5 desc0 write-back", v, 32'h003C_5852);
    rd(A_SRC, v);       check("R9 TXF only", v, 32'h01);
    wait_req("R4 request desc1");
    check("R4 tx_addr desc1", tx_addr, 32'h0000_2000);
    finish_tx(9'h004);
    rd(bd_at(1, 0), v); check("R5 desc1 write-back", v, 32'h0064_6804);
    rd(A_SRC, v);       check("R9 TXE added", v, 32'h03);
    idle(5);
    check("R8 tx wrapped, desc2 not taken", 32'(tx_req), 32'd0);
    rd(bd_at(2, 0), v); check("R8 desc2 untouched", v, 32'h0010_8000);
    wr(A_SRC, 32'h03);
    rd(A_SRC, v);       check("R10 write-one clear", v, 32'h0);
    wr(bd_at(0, 1), 32'h0000_3000); wr(bd_at(0, 0), 32'h0020_8000);
    wait_req("R8 request after wrap");
    check("R8 wrapped to index 0", tx_addr, 32'h0000_3000);
    finish_tx(9'h000);
    rd(A_SRC, v);       check("R9 no source without irq bit", v, 32'h0);
    rd(bd_at(0, 0), v); check("R5 desc0 second write-back", v, 32'h0020_0000);
  endtask

  task automatic t_tx_disable;
    logic [31:0] v;
    wr(A_MODE, 32'h0);
    wr(bd_at(0, 1), 32'h0000_4000); wr(bd_at(0, 0), 32'h0010_8000);
    idle(4);
    check("R11 no request while disabled", 32'(tx_req), 32'd0);
    wr(A_MODE, 32'h2);
    wait_req("R11 request after re-enable");
    check("R11 tx pointer back at 0", tx_addr, 32'h0000_4000);
    finish_tx(9'h000);
    wr(A_MODE, 32'h0);
    rd(A_SRC, v); check("R9 no source after quiet frame", v, 32'h0);
  endtask

  task automatic t_rx;
    logic [31:0] v;
    wr(bd_at(4, 0), 32'h0000_C000); wr(bd_at(4, 1), 32'h0000_A000);
    wr(bd_at(5, 0), 32'h0000_E000); wr(bd_at(5, 1), 32'h0000_B000);
    wr(A_MODE, 32'h1);
    check("R6 rx_buf_addr at ring start", rx_buf_addr, 32'h0000_A000);
    check("R6 rx_buf_ok", 32'(rx_buf_ok), 32'd1);
    frame_in(16'd68, 9'h100);
    rd(bd_at(4, 0), v); check("R6 desc4 write-back", v, 32'h0044_4100);
    rd(A_SRC, v);       check("R9 RXF and RXC", v, 32'h44);
    check("R8 rx stepped to desc5", rx_buf_addr, 32'h0000_B000);
    frame_in(16'd70, 9'h002);
    rd(bd_at(5, 0), v); check("R6 desc5 write-back", v, 32'h0046_6002);
    rd(A_SRC, v);       check("R9 RXE added", v, 32'h4C);
    check("R8 rx wrapped to index N", rx_buf_addr, 32'h0000_A000);
    check("R6 rx_buf_ok low on used desc", 32'(rx_buf_ok), 32'd0);
  endtask

  task automatic t_busy;
    logic [31:0] v;
    frame_in(16'd80, 9'h000);
    rd(A_SRC, v);       check("R7 busy source", v, 32'h5C);
    rd(bd_at(4, 0), v); check("R7 descriptor unchanged", v, 32'h0044_4100);
    check("R7 pointer unchanged", rx_buf_addr, 32'h0000_A000);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    check("R10 irq masked off", 32'(irq), 32'd0);
    wr(A_MASK, 32'h10);
    check("R10 irq on busy", 32'(irq), 32'd1);
    wr(A_SRC, 32'h10);
    rd(A_SRC, v); check("R10 busy cleared only", v, 32'h4C);
    check("R10 irq drops", 32'(irq), 32'd0);
    wr(A_SRC, 32'h7F);
    rd(A_SRC, v); check("R10 all cleared", v, 32'h0);
  endtask

  task automatic t_rx_disable;
    logic [31:0] v;
    wr(bd_at(4, 0), 32'h0000_C000);
    frame_in(16'd64, 9'h000);
    check("R11 pointer at desc5", rx_buf_addr, 32'h0000_B000);
    wr(A_SRC, 32'h7F);
    wr(bd_at(5, 0), 32'h0000_E000);
    wr(A_MODE, 32'h0);
    frame_in(16'd90, 9'h000);
    rd(bd_at(5, 0), v); check("R11 arrive ignored, desc5 unchanged", v, 32'h0000_E000);
    rd(A_SRC, v);       check("R11 arrive ignored, no source", v, 32'h0);
    check("R11 rx_buf_ok low when disabled", 32'(rx_buf_ok), 32'd0);
    wr(A_MODE, 32'h1);
    check("R11 rx pointer back at index N", rx_buf_addr, 32'h0000_A000);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1-R11 run actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_count();
    t_map();
    t_tx();
    t_tx_disable();
    t_rx();
    t_busy();
    t_mask();
    t_rx_disable();
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule